// File: doc/BRIEF.md
# Multi-Mode Two-Wire Serial EEPROM Slave

This block models the slave side of a two-wire serial EEPROM with its storage array built in. It sees the clock line (SCL) and data line (SDA) as samples already in the system clock domain. It frames transfers with START and STOP conditions and counts bit cycles. It shifts in a header byte and the address bytes, stores written bytes, and returns stored bytes on a single output bit that the surrounding logic drives onto the bus.

A static mode input selects one of three addressing schemes.
- Legacy mode (mode 0): the first byte carries a 7-bit word address and the read/write flag. Pages are four bytes.
- One-address-byte mode (mode 1): a control byte is followed by a single address byte, and three select bits of the control byte extend the address to 11 bits.
- Two-address-byte mode (mode 2, with mode 3 treated the same): two address bytes give a 13-bit address.

Both control-byte modes have 16-byte write pages and unbounded sequential reads. A random read is a dummy write of the address followed by a repeated START with the read flag set.

The array holds 2^MEM_AW bytes (2 KB by default). It is indexed by the low MEM_AW bits of the internal address, so wider addresses alias.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset the transfer is idle, `sda_o` equals `sda_i`, and every array byte reads as 0xFF.
- R2: A START (SDA falling while SCL is high) clears the bit counter and opens a transfer. A STOP (SDA rising while SCL is high) closes it. SCL pulses outside a transfer change no stored byte.
- R3: During a transfer, each SCL rising edge advances the bit counter, which never exceeds 36. Header, address and data bits are taken from SDA on SCL falling edges, most significant bit first.
- R4: In mode 0 the first byte holds the word address in bits 7:1 and the R/W flag in bit 0 (1 = read). Written bytes follow, and after each one only address bits 1:0 advance, so the page is four bytes.
- R5: A mode 0 read returns bytes from consecutive word addresses, and the word address wraps within 128.
- R6: In mode 1 the control byte is 1010 s2 s1 s0 R/W. Its bits 3:1 become address bits 10:8, and the following address byte gives bits 7:0.
- R7: In modes 2 and 3 the first address byte supplies address bits 12:8 (its upper three bits are dropped) and the second supplies bits 7:0.
- R8: In the control-byte modes any number of data bytes may follow the address. After each byte only address bits 3:0 advance, wrapping inside a 16-byte page and leaving the upper bits unchanged.
- R9: In a control-byte mode read, the address advances by one per byte across page boundaries, modulo 2^13. The address set by a dummy write survives a repeated START.
- R10: While reading, in bit cycles 10 to 17 `sda_o` carries bit (17 − count) of the addressed byte. At all other times it echoes `sda_i`.
- R11: Acknowledge slots (counts 9, 18 and 27 in the control-byte modes, 9 in mode 0) latch nothing, whatever level SDA has during them. A byte is stored only at the falling edge that completes it.
- R12: A data byte cut short by STOP is not stored.
- R13: The array is indexed by address bits MEM_AW−1:0, so any address with equal low bits reaches the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all samples are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Addressing scheme: 0 legacy, 1 one address byte, 2 or 3 two address bytes; held static |
| scl_i | input | 1 | Synchronous sample of the serial clock line |
| sda_i | input | 1 | Synchronous sample of the serial data line |
| sda_o | output | 1 | Data bit the slave presents to the bus |

## Verification
A behavioural bus master runs byte writes, writes that cross a page edge, random reads and multi-byte sequential reads in each mode. A reference array, updated by the page rules, predicts every byte returned. Page-crossing writes separate a low-bit-only increment from a full increment. Reads that run past a page edge show that reads advance the full address while writes do not. A mode 2 write read back through mode 1 exposes address aliasing. Directed cases send clock pulses with no START, end a byte early with STOP, drive a low level during acknowledge slots, and write bytes whose top and bottom bits differ to expose the bit order.

// File: rtl/eep_pkg.sv
// Shared constants and types for the two-wire EEPROM slave.
package eep_pkg;
    localparam int ADDR_W = 13;            // widest internal address
    localparam int CYC_W  = 6;             // bit counter width (0..36)

    localparam logic [1:0] MODE_LEGACY  = 2'd0;
    localparam logic [1:0] MODE_ONE_ADR = 2'd1;

    // One byte store request towards the array.
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } eep_wreq_t;
endpackage

// File: rtl/eep_line_events.sv
// Detects bus events from the synchronous SCL/SDA samples.
// Assumes both inputs are already in the clk domain; idle bus level is high.
module eep_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    // keep the previous sample of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // edge and condition decode
    always_comb begin
        rise_o  = !scl_q && scl_i;
        fall_o  = scl_q && !scl_i;
        start_o = scl_q && scl_i && sda_q && !sda_i;
        stop_o  = scl_q && scl_i && !sda_q && sda_i;
    end
endmodule

// File: rtl/eep_bit_seq.sv
// Bit-cycle sequencer: counter, header byte, address register and
// write-data shifter for the three addressing schemes.
// Assumes mode_i is static during a transfer.
module eep_bit_seq
    import eep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    output logic              active_o,
    output logic [CYC_W-1:0]  cyc_o,
    output logic              read_o,
    output logic [ADDR_W-1:0] addr_o,
    output eep_wreq_t         wreq_o
);
    localparam int HI_PAD = ADDR_W - 11;

    logic              active_q;
    logic [CYC_W-1:0]  cyc_q, cyc_inc, cyc_next;
    logic [7:0]        hdr_q, dsr_q;
    logic [ADDR_W-1:0] addr_q, sh_addr;
    eep_wreq_t         wreq_q;

    logic is_leg, is_one, is_two, is_ack, data_phase;
    logic rd_wrap, hdr_bit, wr_bit, byte_done, adr_bit, leg_load;

    // mode and cycle classification
    always_comb begin
        is_leg     = (mode_i == MODE_LEGACY);
        is_one     = (mode_i == MODE_ONE_ADR);
        is_two     = mode_i[1];
        cyc_inc    = cyc_q + 1'b1;
        is_ack     = (cyc_q == 6'd9) || (cyc_q == 6'd18) || (cyc_q == 6'd27);
        data_phase = (is_one && cyc_q > 6'd18) || (is_two && cyc_q > 6'd27);
        sh_addr    = {addr_q[ADDR_W-2:0], sda_i};
    end

    // next count on a rising edge, including the per-byte wraps
    always_comb begin
        rd_wrap  = hdr_q[0] && (cyc_inc == 6'd18);
        cyc_next = cyc_inc;
        if (is_leg) begin
            if (cyc_inc == 6'd18) cyc_next = 6'd9;
        end else if (rd_wrap) begin
            cyc_next = 6'd9;
        end else if (is_one && cyc_inc == 6'd27) begin
            cyc_next = 6'd18;
        end else if (cyc_inc == 6'd36) begin
            cyc_next = 6'd27;
        end
    end

    // falling-edge actions for this cycle
    always_comb begin
        hdr_bit   = active_q && fall_i && cyc_q >= 6'd1 && cyc_q <= 6'd8;
        leg_load  = hdr_bit && is_leg && cyc_q == 6'd8;
        wr_bit    = active_q && fall_i && !hdr_q[0] &&
                    (is_leg ? (cyc_q >= 6'd10 && cyc_q <= 6'd17)
                            : (data_phase && !is_ack));
        byte_done = wr_bit && (is_leg ? cyc_q == 6'd17
                                      : (is_one ? cyc_q == 6'd26 : cyc_q == 6'd35));
        adr_bit   = active_q && fall_i && !is_leg && !hdr_q[0] &&
                    cyc_q > 6'd9 && !is_ack && !data_phase;
    end

    // transfer framing and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cyc_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cyc_q    <= '0;
        end else if (stop_i) begin
            active_q <= 1'b0;
            cyc_q    <= '0;
        end else if (active_q && rise_i) begin
            cyc_q    <= cyc_next;
        end
    end

    // header byte shifter (address/flag in mode 0, control byte otherwise)
    always_ff @(posedge clk) begin
        if (!rst_n)       hdr_q <= '0;
        else if (hdr_bit) hdr_q <= {hdr_q[6:0], sda_i};
    end

    // write data shifter
    always_ff @(posedge clk) begin
        if (!rst_n)      dsr_q <= '0;
        else if (wr_bit) dsr_q <= {dsr_q[6:0], sda_i};
    end

    // address register: load, shift, page increment, read increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (leg_load) begin
            addr_q <= ADDR_W'(hdr_q[6:0]);
        end else if (adr_bit) begin
            if (is_one && cyc_q == 6'd17)
                addr_q <= {{HI_PAD{1'b0}}, hdr_q[3:1], sh_addr[7:0]};
            else if (is_one)
                addr_q <= {{(ADDR_W-8){1'b0}}, sh_addr[7:0]};
            else
                addr_q <= sh_addr;
        end else if (byte_done) begin
            if (is_leg) addr_q <= {addr_q[ADDR_W-1:2], addr_q[1:0] + 2'd1};
            else        addr_q <= {addr_q[ADDR_W-1:4], addr_q[3:0] + 4'd1};
        end else if (active_q && rise_i && rd_wrap) begin
            if (is_leg) addr_q <= {addr_q[ADDR_W-1:7], addr_q[6:0] + 7'd1};
            else        addr_q <= addr_q + 1'b1;
        end
    end

    // registered store request, issued once per completed byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreq_q <= '0;
        end else begin
            wreq_q.en <= byte_done;
            if (byte_done) begin
                wreq_q.addr <= addr_q;
                wreq_q.data <= {dsr_q[6:0], sda_i};
            end
        end
    end

    assign active_o = active_q;
    assign cyc_o    = cyc_q;
    assign read_o   = hdr_q[0];
    assign addr_o   = addr_q;
    assign wreq_o   = wreq_q;
endmodule

// File: rtl/eep_array.sv
// Byte storage array with one write port and one combinational read port.
// Assumes addresses are already cut to MEM_AW bits; reset fills with 0xFF.
module eep_array #(
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MEM_AW-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [MEM_AW-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem_q [DEPTH];

    // blank on reset, store one byte per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // read port
    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_2w_slave.sv
// Top of the two-wire EEPROM slave: event decode, sequencer, array and
// output bit selection. Assumes MEM_AW < 13 and synchronous line samples.
module eeprom_2w_slave
    import eep_pkg::*;
#(
    parameter int MEM_AW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o
);
    logic              ev_rise, ev_fall, ev_start, ev_stop;
    logic              seq_active, seq_read;
    logic [CYC_W-1:0]  seq_cyc;
    logic [ADDR_W-1:0] seq_addr;
    eep_wreq_t         wreq;
    logic [7:0]        rd_byte;
    logic [2:0]        bit_sel;
    logic              in_rd_window;
    logic              unused_hi;

    eep_line_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall),
        .start_o (ev_start),
        .stop_o  (ev_stop)
    );

    eep_bit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .rise_i   (ev_rise),
        .fall_i   (ev_fall),
        .start_i  (ev_start),
        .stop_i   (ev_stop),
        .sda_i    (sda_i),
        .active_o (seq_active),
        .cyc_o    (seq_cyc),
        .read_o   (seq_read),
        .addr_o   (seq_addr),
        .wreq_o   (wreq)
    );

    eep_array #(.MEM_AW(MEM_AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wreq.en),
        .waddr_i (wreq.addr[MEM_AW-1:0]),
        .wdata_i (wreq.data),
        .raddr_i (seq_addr[MEM_AW-1:0]),
        .rdata_o (rd_byte)
    );

    assign unused_hi = ^{wreq.addr[ADDR_W-1:MEM_AW], seq_addr[ADDR_W-1:MEM_AW]};

    // pick the stored bit during read data cycles, otherwise echo the line
    always_comb begin
        in_rd_window = seq_active && seq_read &&
                       seq_cyc >= 6'd10 && seq_cyc <= 6'd17;
        bit_sel      = 3'(6'd17 - seq_cyc);
        sda_o        = in_rd_window ? rd_byte[bit_sel] : sda_i;
    end
endmodule

// File: rtl/eep_checker.sv
// Protocol checker bound to the slave top; observes events and sequencer state.
module eep_checker
    import eep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sda_i,
    input logic             sda_o,
    input logic             active,
    input logic [CYC_W-1:0] cyc,
    input logic             start,
    input logic             stop,
    input logic             fall,
    input logic             wr_en
);
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && cyc == '0));

    assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active);

    assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc <= 6'd36);

    assert_store_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(fall));

    assert_store_not_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(cyc) == 6'd17 || $past(cyc) == 6'd26 || $past(cyc) == 6'd35));

    assert_idle_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sda_o == sda_i));
endmodule

bind eeprom_2w_slave eep_checker u_eep_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sda_i  (sda_i),
    .sda_o  (sda_o),
    .active (seq_active),
    .cyc    (seq_cyc),
    .start  (ev_start),
    .stop   (ev_stop),
    .fall   (ev_fall),
    .wr_en  (wreq.en)
);

// File: tb/test_eeprom_2w_slave.sv
module test_eeprom_2w_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       sda_o;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] refm [2048];

    always #10 clk = ~clk;

    eeprom_2w_slave i_eeprom_2w_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .scl_i  (scl),
        .sda_i  (sda),
        .sda_o  (sda_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        rd;
        logic [12:0] addr;
        logic [3:0]  len;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 13'h0123, 4'd3,  8'h11},
        '{2'd1, 1'b1, 13'h0123, 4'd3,  8'h00},
        '{2'd1, 1'b0, 13'h05FD, 4'd5,  8'h40},
        '{2'd1, 1'b1, 13'h05F0, 4'd15, 8'h00},
        '{2'd1, 1'b1, 13'h05FE, 4'd4,  8'h00},
        '{2'd2, 1'b0, 13'h1ABE, 4'd4,  8'h9C},
        '{2'd2, 1'b1, 13'h1AB0, 4'd15, 8'h00},
        '{2'd0, 1'b0, 13'h007E, 4'd4,  8'h21},
        '{2'd0, 1'b1, 13'h007C, 4'd5,  8'h00},
        '{2'd3, 1'b0, 13'h0042, 4'd2,  8'h5A},
        '{2'd2, 1'b1, 13'h0042, 4'd2,  8'h00},
        '{2'd1, 1'b1, 13'h07FF, 4'd2,  8'h00}
    };

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic m_bit(input logic b);
        scl = 1'b0; hold(1);
        sda = b;    hold(3);
        scl = 1'b1; hold(4);
        scl = 1'b0; hold(1);
    endtask

    task automatic m_rbit(output logic b);
        scl = 1'b0; hold(1);
        sda = 1'b1; hold(3);
        scl = 1'b1; hold(3);
        b = sda_o;  hold(1);
        scl = 1'b0; hold(1);
    endtask

    task automatic m_start;
        sda = 1'b1; hold(2);
        scl = 1'b1; hold(3);
        sda = 1'b0; hold(3);
        scl = 1'b0; hold(2);
    endtask

    task automatic m_stop;
        scl = 1'b0; hold(1);
        sda = 1'b0; hold(2);
        scl = 1'b1; hold(3);
        sda = 1'b1; hold(3);
    endtask

    task automatic m_wbyte(input logic [7:0] v, input logic ackv);
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
        m_bit(ackv);
    endtask

    task automatic m_rbyte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_bit(1'b0);
    endtask

    // header plus address bytes of a write-direction frame
    task automatic send_target(input logic [1:0] md, input logic [12:0] a, input logic ackv);
        if (md == 2'd1) begin
            m_wbyte({4'hA, a[10:8], 1'b0}, ackv);
            m_wbyte(a[7:0], ackv);
        end else begin
            m_wbyte(8'hA0, ackv);
            m_wbyte({3'b111, a[12:8]}, ackv);
            m_wbyte(a[7:0], ackv);
        end
    endtask

    task automatic write_tx(input logic [1:0] md, input logic [12:0] a, input int len,
                            input logic [7:0] seed, input logic ackv);
        int cur;
        logic [7:0] d;
        mode = md;
        m_start;
        if (md == 2'd0) begin
            m_wbyte({a[6:0], 1'b0}, ackv);
            cur = int'(a) & 'h7F;
        end else begin
            send_target(md, a, ackv);
            cur = (md == 2'd1) ? (int'(a) & 'h7FF) : (int'(a) & 'h1FFF);
        end
        for (int i = 0; i < len; i++) begin
            d = seed + 8'(i * 37);
            m_wbyte(d, ackv);
            refm[cur & 'h7FF] = d;
            if (md == 2'd0) cur = (cur & ~3)  | ((cur + 1) & 3);
            else            cur = (cur & ~15) | ((cur + 1) & 15);
        end
        m_stop;
    endtask

    task automatic read_tx(input logic [1:0] md, input logic [12:0] a, input int len,
                           input string req);
        int cur;
        logic [7:0] got;
        mode = md;
        m_start;
        if (md == 2'd0) begin
            m_wbyte({a[6:0], 1'b1}, 1'b1);
            cur = int'(a) & 'h7F;
        end else begin
            send_target(md, a, 1'b1);
            m_start;
            m_wbyte(8'hA1, 1'b1);
            cur = (md == 2'd1) ? (int'(a) & 'h7FF) : (int'(a) & 'h1FFF);
        end
        for (int i = 0; i < len; i++) begin
            m_rbyte(got);
            chk(req, got, refm[cur & 'h7FF]);
            if (md == 2'd0) cur = (cur + 1) & 'h7F;
            else            cur = (cur + 1) & 'h1FFF;
        end
        m_stop;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        for (int i = 0; i < 2048; i++) refm[i] = 8'hFF;
        hold(5);
        rst_n = 1'b1;
        hold(2);

        // R1 / R10: idle output echoes the line (changed while SCL is low)
        scl = 1'b0; hold(2);
        sda = 1'b0; hold(2);
        chk("R1 idle echo low", {7'd0, sda_o}, 8'h00);
        sda = 1'b1; hold(2);
        chk("R10 idle echo high", {7'd0, sda_o}, 8'h01);
        scl = 1'b1; hold(3);
        read_tx(2'd1, 13'h0300, 2, "R1 blank array");

        // table of writes and reads
        for (int v = 0; v < NV; v++) begin
            if (!VECS[v].rd) begin
                write_tx(VECS[v].mode, VECS[v].addr, int'(VECS[v].len), VECS[v].seed, 1'b1);
            end else begin
                if (VECS[v].mode == 2'd0)      tag = "R4/R5";
                else if (VECS[v].mode == 2'd1) tag = "R6/R8/R9";
                else                           tag = "R7/R8/R9";
                read_tx(VECS[v].mode, VECS[v].addr, int'(VECS[v].len), tag);
            end
        end

        // R13: mode 2 write at 0x1ABE lands at index 0x2BE, seen through mode 1
        read_tx(2'd1, 13'h02BE, 2, "R13 alias");

        // R2: clock pulses with no START must not store anything
        mode = 2'd1;
        m_wbyte(8'hA2, 1'b1);
        m_wbyte(8'h23, 1'b1);
        m_wbyte(8'h00, 1'b1);
        m_stop;
        read_tx(2'd1, 13'h0123, 1, "R2 no start");

        // R12: byte cut short by STOP
        mode = 2'd1;
        m_start;
        m_wbyte(8'hA4, 1'b1);
        m_wbyte(8'h00, 1'b1);
        for (int i = 0; i < 5; i++) m_bit(1'b0);
        m_stop;
        read_tx(2'd1, 13'h0200, 1, "R12 partial byte");

        // R11: low level during acknowledge slots latches nothing
        write_tx(2'd1, 13'h0400, 3, 8'h3C, 1'b0);
        write_tx(2'd2, 13'h0500, 2, 8'hC3, 1'b0);
        read_tx(2'd1, 13'h0400, 3, "R11 ack low mode1");
        read_tx(2'd2, 13'h0500, 2, "R11 ack low mode2");

        // R3 / R10: bit order with asymmetric bytes (0x80, 0xA5, 0xCA)
        write_tx(2'd1, 13'h0610, 3, 8'h80, 1'b1);
        read_tx(2'd1, 13'h0610, 3, "R3/R10 bit order");
        write_tx(2'd0, 13'h0011, 1, 8'h01, 1'b1);
        read_tx(2'd0, 13'h0011, 1, "R3/R4 legacy bit order");

        finish_run();
    end
endmodule